// File: doc/BRIEF.md
# Quiet Single-Precision Compare Unit

This unit takes two IEEE-754 binary32 operands and reports how they relate. The answer is a 32-bit result word. Its low four bits are a one-hot code: A below B, A equal to B, A above B, or the pair unordered. The next two bits flag which operands are subnormal. All bits above these are zero. A separate invalid output goes to the floating-point status logic and is raised only when a signaling NaN is present. The compare is quiet, so a quiet NaN never raises it. Subnormal operands keep their exact value. They are not flushed to zero, so the smallest subnormal compares above zero.

Operands enter on a valid/ready stream. The result leaves on a second valid/ready stream exactly one cycle after an operand pair is accepted. The unit has a single output register. `in_ready` is high when that register is empty or is being drained in the same cycle, so back-to-back pairs flow at one per cycle while `out_ready` stays high. When `out_valid` is high and `out_ready` is low, the result and the invalid flag are held unchanged. No new pair is accepted until the consumer takes the held result.

Top module: `fcmp_quiet_top`

## Requirements
- R1: Result bit 0 is set for A < B, bit 1 for A == B, bit 2 for A > B and bit 3 for an unordered pair.
- R2: Exactly one of result bits 0 to 3 is set in every valid result.
- R3: Result bit 4 is set when A is subnormal, meaning a zero exponent field with a nonzero fraction. Bit 5 is the same test applied to B. A NaN, an infinity or a zero never sets these bits.
- R4: Subnormal operands are compared by their true value and are not flushed. For example, 0x00000001 is greater than 0x00000000, and 0x007FFFFF is less than 0x00800000.
- R5: `out_invalid` is 1 exactly when at least one operand is a signaling NaN. A signaling NaN has an all-ones exponent, fraction bit 22 equal to 0 and a nonzero fraction. A quiet NaN (fraction bit 22 equal to 1) gives no invalid.
- R6: Positive zero (0x00000000) and negative zero (0x80000000) compare equal.
- R7: If either operand is any NaN, the result is unordered and bits 0 to 2 are clear.
- R8: Result bits 31 down to 6 are always zero.
- R9: Two non-NaN values of the same sign are ordered by magnitude, and the order is reversed when both are negative. Infinities are the extreme magnitudes.
- R10: A pair is accepted when `in_valid` and `in_ready` are both high, and its result appears with `out_valid` on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and `out_invalid` stay stable and no new pair is accepted.
- R11: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can accept a pair this cycle |
| in_a | input | 32 | Operand A, binary32 |
| in_b | input | 32 | Operand B, binary32 |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Relation code in bits 3:0, subnormal flags in bits 5:4, zero above |
| out_invalid | output | 1 | Signaling NaN seen in the pair of this result |

## Verification
Every fault in the classification or relation logic shows in the result word one cycle after acceptance. Possible symptoms are a wrong or multiple relation bit, a missing subnormal flag, or an invalid flag raised on a quiet NaN. The vector table covers each sign, zero, subnormal, infinity and NaN combination, so such faults appear on the first affected vector. A faulty output register or handshake shows up in two ways. A stalled result may change before it is consumed. Alternatively, `in_ready` may stay high while the register is full, and the directed back-pressure test reads both of these within two cycles.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  // Bit positions inside the result word (decoded by the consumer).
  localparam int RBIT_LT    = 0;
  localparam int RBIT_EQ    = 1;
  localparam int RBIT_GT    = 2;
  localparam int RBIT_UN    = 3;
  localparam int RBIT_SUB_A = 4;
  localparam int RBIT_SUB_B = 5;
  localparam int REL_W      = 4;
  localparam int FLAG_TOP   = 6;

  // Relation selector used inside the compare logic.
  typedef enum logic [1:0] {
    REL_LESS  = 2'd0,
    REL_EQUAL = 2'd1,
    REL_MORE  = 2'd2,
    REL_NONE  = 2'd3
  } rel_e;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op,
  output logic         sign,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero,
  output logic         is_sub,
  output logic [W-2:0] mag
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;
  logic exp_full, exp_empty, frac_any;

  always_comb begin
    sign      = op[W-1];
    expo      = op[W-2:MAN_W];
    frac      = op[MAN_W-1:0];
    mag       = op[W-2:0];
    exp_full  = &expo;
    exp_empty = ~|expo;
    frac_any  = |frac;
    is_nan    = exp_full && frac_any;
    is_snan   = is_nan && !frac[MAN_W-1];
    is_zero   = exp_empty && !frac_any;
    is_sub    = exp_empty && frac_any;
  end
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         sign_a,
  input  logic         nan_a,
  input  logic         zero_a,
  input  logic [W-2:0] mag_a,
  input  logic         sign_b,
  input  logic         nan_b,
  input  logic         zero_b,
  input  logic [W-2:0] mag_b,
  output logic [fcmp_pkg::REL_W-1:0] rel
);
  import fcmp_pkg::*;

  logic [W-1:0] key_a, key_b;
  rel_e         sel;

  // Map sign-magnitude onto an unsigned ordered key; zeros fold to one key.
  function automatic logic [W-1:0] order_key(input logic s, input logic z,
                                             input logic [W-2:0] m);
    if (z)      return {1'b1, {(W-1){1'b0}}};
    else if (s) return {1'b0, ~m};
    else        return {1'b1, m};
  endfunction

  always_comb begin
    key_a = order_key(sign_a, zero_a, mag_a);
    key_b = order_key(sign_b, zero_b, mag_b);
    if (nan_a || nan_b)     sel = REL_NONE;
    else if (key_a < key_b) sel = REL_LESS;
    else if (key_a > key_b) sel = REL_MORE;
    else                    sel = REL_EQUAL;
    rel = '0;
    unique case (sel)
      REL_LESS:  rel[RBIT_LT] = 1'b1;
      REL_EQUAL: rel[RBIT_EQ] = 1'b1;
      REL_MORE:  rel[RBIT_GT] = 1'b1;
      default:   rel[RBIT_UN] = 1'b1;
    endcase
  end
endmodule

// File: rtl/fcmp_out_stage.sv
module fcmp_out_stage #(
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RES_W-1:0] d_result,
  input  logic             d_invalid,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] q_result,
  output logic             q_invalid
);
  logic take;

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_result  <= '0;
      q_invalid <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        q_result  <= d_result;
        q_invalid <= d_invalid;
      end
    end
  end

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_result) && $stable(q_invalid)));

  assert_accept_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/fcmp_quiet_top.sv
module fcmp_quiet_top #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1+EXP_W+MAN_W-1:0] in_a,
  input  logic [1+EXP_W+MAN_W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_result,
  output logic             out_invalid
);
  import fcmp_pkg::*;

  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int N_OP  = 2;
  localparam int PAD_W = RES_W - FLAG_TOP;

  logic [W-1:0] ops [N_OP];
  logic         sgn [N_OP];
  logic         nan [N_OP];
  logic         snan[N_OP];
  logic         zer [N_OP];
  logic         sub [N_OP];
  logic [W-2:0] mag [N_OP];

  logic [REL_W-1:0] rel;
  logic [RES_W-1:0] word;
  logic             inv;

  always_comb begin
    ops[0] = in_a;
    ops[1] = in_b;
  end

  for (genvar g = 0; g < N_OP; g++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op(ops[g]), .sign(sgn[g]), .is_nan(nan[g]), .is_snan(snan[g]),
      .is_zero(zer[g]), .is_sub(sub[g]), .mag(mag[g])
    );
  end

  fcmp_relation #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
    .sign_a(sgn[0]), .nan_a(nan[0]), .zero_a(zer[0]), .mag_a(mag[0]),
    .sign_b(sgn[1]), .nan_b(nan[1]), .zero_b(zer[1]), .mag_b(mag[1]),
    .rel(rel)
  );

  always_comb begin
    word = {{PAD_W{1'b0}}, sub[1], sub[0], rel};
    inv  = snan[0] || snan[1];
  end

  fcmp_out_stage #(.RES_W(RES_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_result(word), .d_invalid(inv), .out_valid(out_valid),
    .out_ready(out_ready), .q_result(out_result), .q_invalid(out_invalid)
  );

  assert_onehot_rel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_result[RBIT_UN:RBIT_LT]) == 1));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[RES_W-1:FLAG_TOP] == '0));

  assert_invalid_unordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> out_result[RBIT_UN]);

  assert_nan_clears_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_result[RBIT_UN]) |-> (out_result[RBIT_GT:RBIT_LT] == 3'b000));
endmodule

// File: tb/fcmp_quiet_top_tb.sv
module fcmp_quiet_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_invalid;

  int runs = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_quiet_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_invalid(out_invalid)
  );

  // A, B, expected result word, expected invalid, requirement tag
  localparam logic [31:0] T_A [NV] = '{
    32'h3F800000, 32'h40000000, 32'h3F800000, 32'h00000000, 32'hBF800000,
    32'hC0000000, 32'h00000001, 32'h00000000, 32'h00000001, 32'h7FC00000,
    32'h3F800000, 32'h7F800000, 32'hFF800000, 32'h007FFFFF, 32'hFFC00000,
    32'hFFA00000, 32'h7F800000, 32'hBF800000};
  localparam logic [31:0] T_B [NV] = '{
    32'h40000000, 32'h3F800000, 32'h3F800000, 32'h80000000, 32'hC0000000,
    32'hBF800000, 32'h00000000, 32'h80000001, 32'h00000002, 32'h3F800000,
    32'h7F800001, 32'h7F7FFFFF, 32'hBF800000, 32'h00800000, 32'h00000001,
    32'hFFA00000, 32'h7F800000, 32'h00000000};
  localparam logic [31:0] T_E [NV] = '{
    32'h01, 32'h04, 32'h02, 32'h02, 32'h04,
    32'h01, 32'h14, 32'h24, 32'h31, 32'h08,
    32'h08, 32'h04, 32'h01, 32'h11, 32'h28,
    32'h08, 32'h02, 32'h01};
  localparam logic T_I [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam string T_R [NV] = '{
    "R1", "R1", "R1", "R6", "R9", "R9", "R4/R3", "R3", "R3",
    "R5/R7", "R5", "R9", "R9", "R4", "R7/R3", "R5", "R1", "R1"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk);
    check("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R11 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table, one pair at a time
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1; in_a = T_A[i]; in_b = T_B[i];
      @(negedge clk);
      in_valid = 1'b0;
      check({T_R[i], " valid"}, {31'd0, out_valid}, 32'd1);
      check({T_R[i], " result"}, out_result, T_E[i]);
      check({T_R[i], " invalid"}, {31'd0, out_invalid}, {31'd0, T_I[i]});
      check("R8 upper bits", {6'd0, out_result[31:6]}, 32'd0);
      @(negedge clk);
    end

    // R10 back-to-back stream: two pairs in consecutive cycles
    in_valid = 1'b1; in_a = 32'h3F800000; in_b = 32'h40000000;
    @(negedge clk);
    check("R10 first of burst", out_result, 32'h01);
    in_a = 32'h40000000; in_b = 32'h3F800000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second of burst", out_result, 32'h04);
    @(negedge clk);
    check("R10 drained", {31'd0, out_valid}, 32'd0);

    // R10 back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 32'h7F800001; in_b = 32'h00000000;
    @(negedge clk);
    check("R10 stalled valid", {31'd0, out_valid}, 32'd1);
    check("R10 in_ready low when full", {31'd0, in_ready}, 32'd0);
    check("R5 stalled invalid", {31'd0, out_invalid}, 32'd1);
    in_a = 32'h3F800000; in_b = 32'h3F800000;
    @(negedge clk);
    check("R10 held result", out_result, 32'h08);
    check("R10 held invalid", {31'd0, out_invalid}, 32'd1);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 consumed", {31'd0, out_valid}, 32'd0);

    // R11 reset mid-stream clears a pending result
    out_ready = 1'b0;
    in_valid = 1'b1; in_a = 32'h00000000; in_b = 32'h00000000;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11 reset clears valid", {31'd0, out_valid}, 32'd0);
    check("R11 reset sets ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule